// File: doc/BRIEF.md
# 64-bit SECDED Syndrome Decoder

This block checks one 64-bit data word against the 8 check bits stored with it. It computes fresh check bits from the data through a fixed, irregular parity-check matrix and XORs them with the received check bits to form a syndrome. It then decides whether there is no error, a single faulty data bit, a single faulty check bit, or a pattern it cannot correct. It returns the syndrome, the class, the bit index and the repaired data and check bits.

A caller presents a word with `in_valid`. The result appears on registered outputs on the next clock edge, with `out_valid` high for that one cycle. The result outputs keep their last value while no new word arrives. The decoder tries data-bit columns before check bits, and among data bits the lowest index wins.

Top module: `secded64_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and every result output are cleared to zero on that edge, whatever `in_valid` shows.
- R2: Computed check bit i is the XOR of the data bits picked out by a 64-bit mask {upper half, lower half}, where data[63:32] meets the upper half and data[31:0] the lower half. Upper/lower masks in hex, by check bit: 0: f00fe11e/c33c0ff7, 1: 00ff00ff/00fff0ff, 2: 0f0f0f0f/0f0fff00, 3: 11113333/7777000f, 4: 22224444/8888222f, 5: 44448888/ffff4441, 6: 8888ffff/11118882, 7: ffff1111/22221114.
- R3: `out_syndrome` is the computed check bits XOR `in_check`. A zero syndrome gives class 0 (no error) and index 0, and data and check bits pass through unchanged.
- R4: The column of data bit n has bit i set when mask i includes bit n. A nonzero syndrome equal to some column gives class 1 (data bit), with the index set to the lowest such n. `out_data` is `in_data` with bit n inverted, and `out_check` equals `in_check`.
- R5: A nonzero syndrome that matches no column and has exactly one bit set gives class 2 (check bit), with the index set to that bit position. `out_check` is `in_check` with that bit inverted, and `out_data` equals `in_data`.
- R6: Any other syndrome gives class 3 (uncorrectable) and index 0, and data and check bits pass through unchanged.
- R7: `out_valid` is high in exactly the cycle after `in_valid` was sampled high, and the result of that word appears in the same cycle.
- R8: A cycle with `in_valid` low leaves all result outputs unchanged, even when the data and check inputs change.
- R9: Words presented on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Word on the inputs is to be decoded |
| in_data | input | 64 | Captured data word |
| in_check | input | 8 | Captured check bits |
| out_valid | output | 1 | Result registered this cycle |
| out_syndrome | output | 8 | Computed XOR received check bits |
| out_class | output | 2 | 0 none, 1 data bit, 2 check bit, 3 uncorrectable |
| out_index | output | 6 | Faulty data bit (0..63) or check bit (0..7) |
| out_data | output | 64 | Data with the faulty bit inverted |
| out_check | output | 8 | Check bits with the faulty bit inverted |

## Verification
The hardest cases to reach are syndromes with more than one bit set, where the block must choose between a data-column match (possibly one shadowing a later column) and the uncorrectable class. Single flips almost never produce these. The bench therefore sweeps pairs and triples of flipped bits across data and check positions. It compares each result with a reference model built from the mask table. Words with two check-bit flips produce weight-two syndromes that test whether a data column claims them before the uncorrectable class does.

// File: rtl/secded_pkg.sv
// Package: shared sizes, the parity-check matrix and the result class type.
// Assumes a 64-bit data word protected by 8 check bits.
package secded_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    // Row i selects the data bits folded into check bit i; {upper, lower} word.
    localparam logic [CHK_W-1:0][DATA_W-1:0] ROW_MASK = {
        64'hffff1111_22221114,
        64'h8888ffff_11118882,
        64'h44448888_ffff4441,
        64'h22224444_8888222f,
        64'h11113333_7777000f,
        64'h0f0f0f0f_0f0fff00,
        64'h00ff00ff_00fff0ff,
        64'hf00fe11e_c33c0ff7
    };

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_DATA   = 2'd1,
        CLS_CHECK  = 2'd2,
        CLS_UNCORR = 2'd3
    } err_class_t;

    // Syndrome pattern that a single flip of data bit n produces.
    function automatic logic [CHK_W-1:0] column_of(input int n);
        logic [CHK_W-1:0] c;
        for (int i = 0; i < CHK_W; i++) c[i] = ROW_MASK[i][n];
        return c;
    endfunction
endpackage

// File: rtl/secded_parity_gen.sv
// Module: computes the check bits of a data word from the fixed matrix.
// Assumes ROW_MASK in secded_pkg sized DATA_W x CHK_W.
module secded_parity_gen
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);
    // One XOR tree per check bit over the selected data bits.
    for (genvar i = 0; i < CHK_W; i++) begin : g_row
        assign check_o[i] = ^(data_i & ROW_MASK[i]);
    end
endmodule

// File: rtl/secded_locator.sv
// Module: classifies a syndrome and names the faulty bit.
// Assumes data columns are tried first (lowest index wins), then a
// single-bit syndrome names a check bit; anything else is uncorrectable.
module secded_locator
    import secded_pkg::*;
(
    input  logic [CHK_W-1:0] syndrome_i,
    output err_class_t       class_o,
    output logic [IDX_W-1:0] index_o
);
    localparam int CIDX_W = $clog2(CHK_W);

    logic [DATA_W-1:0] col_hit;
    logic              data_hit;
    logic [IDX_W-1:0]  data_idx;
    logic              single_bit;
    logic [CIDX_W-1:0] chk_idx;
    logic              syn_zero;

    assign syn_zero = (syndrome_i == '0);

    // One constant comparator per data column.
    for (genvar n = 0; n < DATA_W; n++) begin : g_col
        localparam logic [CHK_W-1:0] COL = column_of(n);
        assign col_hit[n] = (syndrome_i == COL);
    end

    // Priority pick of the lowest matching data column.
    always_comb begin
        data_hit = 1'b0;
        data_idx = '0;
        for (int n = DATA_W - 1; n >= 0; n--) begin
            if (col_hit[n] && !syn_zero) begin
                data_hit = 1'b1;
                data_idx = IDX_W'(n);
            end
        end
    end

    // Detect a one-hot syndrome and find its set bit.
    always_comb begin
        single_bit = !syn_zero && ((syndrome_i & (syndrome_i - 1'b1)) == '0);
        chk_idx    = '0;
        for (int i = CHK_W - 1; i >= 0; i--) begin
            if (syndrome_i[i]) chk_idx = CIDX_W'(i);
        end
    end

    // Final class and index selection in priority order.
    always_comb begin
        if (syn_zero) begin
            class_o = CLS_NONE;
            index_o = '0;
        end else if (data_hit) begin
            class_o = CLS_DATA;
            index_o = data_idx;
        end else if (single_bit) begin
            class_o = CLS_CHECK;
            index_o = IDX_W'(chk_idx);
        end else begin
            class_o = CLS_UNCORR;
            index_o = '0;
        end
    end
endmodule

// File: rtl/secded_corrector.sv
// Module: inverts the named data or check bit according to the class.
// Assumes index_o semantics of secded_locator; other classes pass through.
module secded_corrector
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  check_i,
    input  err_class_t        class_i,
    input  logic [IDX_W-1:0]  index_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  check_o
);
    logic [DATA_W-1:0] data_flip;
    logic [CHK_W-1:0]  check_flip;

    // Decode the index into a flip mask for data bits.
    for (genvar n = 0; n < DATA_W; n++) begin : g_dflip
        assign data_flip[n] = (class_i == CLS_DATA) && (index_i == IDX_W'(n));
    end

    // Decode the index into a flip mask for check bits.
    for (genvar i = 0; i < CHK_W; i++) begin : g_cflip
        assign check_flip[i] = (class_i == CLS_CHECK) && (index_i == IDX_W'(i));
    end

    assign data_o  = data_i ^ data_flip;
    assign check_o = check_i ^ check_flip;
endmodule

// File: rtl/secded64_decoder.sv
// Module: top of the SECDED decoder; combinational decode, one output register.
// Assumes synchronous active-low reset; results hold while in_valid is low.
module secded64_decoder
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [63:0]       in_data,
    input  logic [7:0]        in_check,
    output logic              out_valid,
    output logic [7:0]        out_syndrome,
    output logic [1:0]        out_class,
    output logic [5:0]        out_index,
    output logic [63:0]       out_data,
    output logic [7:0]        out_check
);
    logic [CHK_W-1:0]  calc_check;
    logic [CHK_W-1:0]  syndrome;
    err_class_t        cls;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] fix_data;
    logic [CHK_W-1:0]  fix_check;

    secded_parity_gen u_gen (
        .data_i  (in_data),
        .check_o (calc_check)
    );

    assign syndrome = calc_check ^ in_check;

    secded_locator u_loc (
        .syndrome_i (syndrome),
        .class_o    (cls),
        .index_o    (idx)
    );

    secded_corrector u_fix (
        .data_i  (in_data),
        .check_i (in_check),
        .class_i (cls),
        .index_i (idx),
        .data_o  (fix_data),
        .check_o (fix_check)
    );

    // Output valid strobe, one cycle behind in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers, loaded only for a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_syndrome <= '0;
            out_class    <= '0;
            out_index    <= '0;
            out_data     <= '0;
            out_check    <= '0;
        end else if (in_valid) begin
            out_syndrome <= syndrome;
            out_class    <= cls;
            out_index    <= idx;
            out_data     <= fix_data;
            out_check    <= fix_check;
        end
    end
endmodule

// File: rtl/secded64_decoder_chk.sv
// Module: property checker for secded64_decoder, attached by bind.
// Assumes the top's port names; observes only.
module secded64_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_data,
    input logic [7:0]  in_check,
    input logic        out_valid,
    input logic [7:0]  out_syndrome,
    input logic [1:0]  out_class,
    input logic [5:0]  out_index,
    input logic [63:0] out_data,
    input logic [7:0]  out_check
);
    assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_none_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'd0) |->
        (out_syndrome == 8'd0 && out_index == 6'd0 &&
         out_data == $past(in_data) && out_check == $past(in_check)));

    assert_data_single_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'd1) |->
        ($countones(out_data ^ $past(in_data)) == 1 && out_check == $past(in_check)));

    assert_check_single_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'd2) |->
        ($countones(out_syndrome) == 1 && out_data == $past(in_data) &&
         $countones(out_check ^ $past(in_check)) == 1));

    assert_uncorr_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'd3) |->
        ($countones(out_syndrome) > 1 && out_data == $past(in_data) &&
         out_check == $past(in_check)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_check) &&
                       $stable(out_syndrome) && $stable(out_class) && $stable(out_index)));
endmodule

bind secded64_decoder secded64_decoder_chk chk_i (.*);

// File: tb/secded64_decoder_tb_top.sv
// Directed bench for secded64_decoder with a reference model from the mask table.
module secded64_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_check = '0;
    logic        out_valid;
    logic [7:0]  out_syndrome;
    logic [1:0]  out_class;
    logic [5:0]  out_index;
    logic [63:0] out_data;
    logic [7:0]  out_check;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    secded64_decoder dut_i (.*);

    // Mask table from R2, {upper, lower} per check bit.
    function automatic logic [63:0] mask_of(input int i);
        case (i)
            0: return 64'hf00fe11e_c33c0ff7;
            1: return 64'h00ff00ff_00fff0ff;
            2: return 64'h0f0f0f0f_0f0fff00;
            3: return 64'h11113333_7777000f;
            4: return 64'h22224444_8888222f;
            5: return 64'h44448888_ffff4441;
            6: return 64'h8888ffff_11118882;
            default: return 64'hffff1111_22221114;
        endcase
    endfunction

    function automatic logic [7:0] gen_check(input logic [63:0] d);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = ^(d & mask_of(i));
        return c;
    endfunction

    function automatic logic [7:0] col(input int n);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = mask_of(i)[n];
        return c;
    endfunction

    typedef struct packed {
        logic [7:0]  syn;
        logic [1:0]  cls;
        logic [5:0]  idx;
        logic [63:0] dat;
        logic [7:0]  chk;
    } res_t;

    // Expected result per R3..R6.
    function automatic res_t model(input logic [63:0] d, input logic [7:0] c);
        res_t r;
        bit found;
        r.syn = gen_check(d) ^ c;
        r.cls = 2'd0; r.idx = '0; r.dat = d; r.chk = c;
        found = 0;
        if (r.syn != 0) begin
            for (int n = 0; n < 64; n++) begin
                if (!found && col(n) == r.syn) begin
                    found = 1; r.cls = 2'd1; r.idx = 6'(n); r.dat[n] = ~d[n];
                end
            end
            if (!found) begin
                if ($countones(r.syn) == 1) begin
                    for (int i = 0; i < 8; i++)
                        if (r.syn[i]) begin r.cls = 2'd2; r.idx = 6'(i); r.chk[i] = ~c[i]; end
                end else begin
                    r.cls = 2'd3;
                end
            end
        end
        return r;
    endfunction

    function automatic res_t observed();
        res_t r;
        r.syn = out_syndrome; r.cls = out_class; r.idx = out_index;
        r.dat = out_data; r.chk = out_check;
        return r;
    endfunction

    task automatic compare(input string req, input res_t exp_r, input logic exp_v);
        res_t got;
        got = observed();
        n_checks++;
        if (got !== exp_r || out_valid !== exp_v) begin
            n_fails++;
            $display("FAIL %s: got v=%0b syn=%h cls=%0d idx=%0d d=%h c=%h, expected v=%0b syn=%h cls=%0d idx=%0d d=%h c=%h",
                     req, out_valid, got.syn, got.cls, got.idx, got.dat, got.chk,
                     exp_v, exp_r.syn, exp_r.cls, exp_r.idx, exp_r.dat, exp_r.chk);
        end
    endtask

    // Present one word, then check the registered result a cycle later.
    task automatic decode_one(input string req, input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        in_data = d; in_check = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        compare(req, model(d, c), 1'b1);
    endtask

    // R1: reset clears everything even with in_valid high.
    task automatic test_reset();
        res_t zero_r;
        zero_r = '0;
        rst_n = 1'b0;
        in_valid = 1'b1; in_data = 64'hdead_beef_0123_4567; in_check = 8'h5a;
        repeat (3) @(negedge clk);
        compare("R1 reset", zero_r, 1'b0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release", zero_r, 1'b0);
    endtask

    // R2/R3: clean words with correctly generated check bits.
    task automatic test_clean();
        logic [63:0] pats [5] = '{64'h0, 64'hffff_ffff_ffff_ffff, 64'h0123_4567_89ab_cdef,
                                  64'haaaa_5555_f0f0_0f0f, 64'h8000_0000_0000_0001};
        foreach (pats[k]) decode_one("R2/R3 clean word", pats[k], gen_check(pats[k]));
        // R2: known vector, check bits must match mask parity exactly (syndrome reveals).
        decode_one("R2 raw syndrome", 64'h0000_0000_0000_0001, 8'h00);
    endtask

    // R4: every single data-bit flip.
    task automatic test_data_flips();
        logic [63:0] base;
        base = 64'h3c5a_9612_e07f_b4d1;
        for (int n = 0; n < 64; n++)
            decode_one("R4 data flip", base ^ (64'd1 << n), gen_check(base));
    endtask

    // R5: every single check-bit flip.
    task automatic test_check_flips();
        logic [63:0] base;
        base = 64'h7e81_24c3_0f96_5aa5;
        for (int i = 0; i < 8; i++)
            decode_one("R5 check flip", base, gen_check(base) ^ (8'd1 << i));
    endtask

    // R6/R4 priority: multi-bit flips, multi-bit syndromes.
    task automatic test_multi();
        logic [63:0] base;
        base = 64'h1122_3344_5566_7788;
        for (int a = 0; a < 64; a += 5) begin
            int b;
            b = (a + 17) % 64;
            decode_one("R6 double data flip", base ^ (64'd1 << a) ^ (64'd1 << b), gen_check(base));
        end
        for (int i = 0; i < 7; i++)
            decode_one("R6/R4 double check flip", base, gen_check(base) ^ (8'd3 << i));
        decode_one("R6 data+check flip", base ^ 64'd1 << 9, gen_check(base) ^ 8'h80);
        decode_one("R6 triple flip", base ^ 64'h0000_0100_0010_0001, gen_check(base));
        decode_one("R6 all check inverted", base, ~gen_check(base));
    endtask

    // R8: outputs hold while in_valid is low.
    task automatic test_hold();
        res_t exp_r;
        logic [63:0] d;
        d = 64'hcafe_f00d_1234_8765 ^ 64'd1 << 40;
        exp_r = model(d, gen_check(64'hcafe_f00d_1234_8765));
        decode_one("R8 setup", d, gen_check(64'hcafe_f00d_1234_8765));
        for (int k = 0; k < 3; k++) begin
            in_data = ~d ^ 64'(k); in_check = 8'(k * 37);
            @(negedge clk);
            compare("R8 hold while idle", exp_r, 1'b0);
        end
    endtask

    // R7/R9: back-to-back words each yield their own result.
    task automatic test_stream();
        logic [63:0] ds [4] = '{64'h1, 64'h0fed_cba9_8765_4321, 64'hffff_0000_ffff_0000, 64'h5};
        logic [7:0]  cs [4];
        cs[0] = gen_check(ds[0]);
        cs[1] = gen_check(ds[1]) ^ 8'h10;
        cs[2] = gen_check(ds[2] ^ 64'd1 << 63);
        cs[3] = 8'hff;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1; in_data = ds[k]; in_check = cs[k];
            @(negedge clk);
            compare("R9 stream", model(ds[k], cs[k]), 1'b1);
        end
        in_valid = 1'b0;
        @(negedge clk);
        compare("R7 valid drops", model(ds[3], cs[3]), 1'b0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        summary();
    end

    initial begin
        test_reset();
        test_clean();
        test_data_flips();
        test_check_flips();
        test_multi();
        test_hold();
        test_stream();
        summary();
    end
endmodule